// File: doc/BRIEF.md
# SPI Pad System-Test Register

This block is one 32-bit control register of a SPI peripheral, used to test board and chip wiring. When the test-mode input is high, the register takes the SPI pads away from the functional SPI logic. Software then chooses, for each pad group, whether the pad is driven or sampled. It writes the level of each driven pad and reads back the level of each sampled pad. When the test-mode input is low, the functional logic owns the pads and the register has no effect on them.

The register has further controls. One bit drives a wakeup output directly. A sticky "force status" bit makes the interrupt status register set all of its bits. While that bit is set, it also blocks any write-one-to-clear of those status bits. Input pad levels pass through a synchronizer before they can be read. The bus access completes in a single cycle with no wait states.

Top module: `spi_systest_pad`

## Requirements
- R1: After synchronous reset every stored field is 0. A read returns 0, `irq_set_all` and `wake_o` are 0, and in test mode every pad is enabled as an output driven low.
- R2: The register is at byte offset 0x24. Bits 31:12 always read as 0, whatever value was written to them.
- R3: Bit 11 is the force-status bit. Writing 1 raises `irq_set_all` in the next cycle. Writing 0 lowers it. The bit reads back as written.
- R4: While bit 11 is 1, `irq_clr_ok` is all zero. While bit 11 is 0, `irq_clr_ok` equals `irq_clr_req`.
- R5: The direction bits use 1 for input and 0 for output. Bit 10 controls the clock pad and all four chip-select pads. Bit 9 controls data line 1 and bit 8 controls data line 0. In test mode each pad's output enable is the inverse of its direction bit.
- R6: In test mode the driven level of each pad comes from its value bit. The clock is bit 6, data line 1 is bit 5, data line 0 is bit 4, and chip-selects 3..0 are bits 3..0.
- R7: When a value bit's direction is input, a read returns the pad level as seen through a two-stage synchronizer. That level is visible from the second rising edge after the pad changes.
- R8: A write to a value bit is ignored if that bit's direction field holds input when the write happens. The bit then keeps its earlier value.
- R9: Bit 7 drives `wake_o` directly, in test mode and outside it.
- R10: With `test_mode` low, every pad output and output enable equals the matching functional input.
- R11: A write to any other offset changes nothing. A write at offset 0x24 is visible on a read and on the pads in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the read |
| test_mode | input | 1 | Gives the pads to this register |
| irq_clr_req | input | IRQ_W | Write-one-to-clear request for the status bits |
| irq_clr_ok | output | IRQ_W | Clear request after gating by the force bit |
| irq_set_all | output | 1 | Forces every status bit to 1 |
| wake_o | output | 1 | Wakeup signal |
| func_clk_o | input | 1 | Functional clock level |
| func_clk_oe | input | 1 | Functional clock enable |
| func_cs_o | input | 4 | Functional chip-select levels |
| func_cs_oe | input | 4 | Functional chip-select enables |
| func_d_o | input | 2 | Functional data levels |
| func_d_oe | input | 2 | Functional data enables |
| pad_clk_i | input | 1 | Clock pad level |
| pad_cs_i | input | 4 | Chip-select pad levels |
| pad_d_i | input | 2 | Data pad levels |
| pad_clk_o | output | 1 | Clock pad drive |
| pad_clk_oe | output | 1 | Clock pad enable |
| pad_cs_o | output | 4 | Chip-select pad drive |
| pad_cs_oe | output | 4 | Chip-select pad enables |
| pad_d_o | output | 2 | Data pad drive |
| pad_d_oe | output | 2 | Data pad enables |

## Verification
Two functions can land in the same cycle: a write that flips a direction field, and a write to value bits governed by that field. The sweep steps through every direction combination with every value pattern. Each written value therefore lands while the old direction is still in force, and a reference model records whether that write had to be dropped. A second collision is a clear request arriving in the cycle that sets or releases the force bit. The bench checks the gate just before and just after that edge.

// File: rtl/spi_systest_pkg.sv
package spi_systest_pkg;

    localparam int BUS_W     = 32;
    localparam int USED_W    = 12;
    localparam int CS_N      = 4;
    localparam int DAT_N     = 2;
    localparam int PAD_N     = 1 + DAT_N + CS_N;

    // Register image of the used bits, MSB first (bit 11 down to bit 0)
    typedef struct packed {
        logic            force_sts;   // 11
        logic            ckcs_in;     // 10
        logic            d1_in;       // 9
        logic            d0_in;       // 8
        logic            wake;        // 7
        logic            clk_v;       // 6
        logic            d1_v;        // 5
        logic            d0_v;        // 4
        logic [CS_N-1:0] cs_v;        // 3:0
    } sst_reg_t;

    // Pad group vector in value-bit order: clk, d1, d0, cs[3:0]
    typedef struct packed {
        logic            clk;
        logic            d1;
        logic            d0;
        logic [CS_N-1:0] cs;
    } pad_vec_t;

    function automatic pad_vec_t input_mask(sst_reg_t r);
        pad_vec_t m;
        m.clk = r.ckcs_in;
        m.d1  = r.d1_in;
        m.d0  = r.d0_in;
        m.cs  = {CS_N{r.ckcs_in}};
        return m;
    endfunction

    function automatic pad_vec_t values_of(sst_reg_t r);
        pad_vec_t v;
        v.clk = r.clk_v;
        v.d1  = r.d1_v;
        v.d0  = r.d0_v;
        v.cs  = r.cs_v;
        return v;
    endfunction

    function automatic logic [BUS_W-1:0] readback(sst_reg_t r, pad_vec_t pads);
        pad_vec_t m;
        pad_vec_t v;
        logic [BUS_W-1:0] word;
        m = input_mask(r);
        v = (m & pads) | (~m & values_of(r));
        word = '0;
        word[USED_W-1:PAD_N] = {r.force_sts, r.ckcs_in, r.d1_in, r.d0_in, r.wake};
        word[PAD_N-1:0]      = v;
        return word;
    endfunction

endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sst_ctrl_reg.sv
module sst_ctrl_reg
    import spi_systest_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [USED_W-1:0] wbits,
    output sst_reg_t          q
);
    sst_reg_t wr_img;
    sst_reg_t nxt;
    pad_vec_t keep;
    pad_vec_t merged;

    always_comb begin
        wr_img = sst_reg_t'(wbits);
        keep   = input_mask(q);     // direction in force when the write lands
        merged = (keep & values_of(q)) | (~keep & values_of(wr_img));
        nxt    = q;
        if (wr_hit) begin
            nxt.force_sts = wr_img.force_sts;
            nxt.ckcs_in   = wr_img.ckcs_in;
            nxt.d1_in     = wr_img.d1_in;
            nxt.d0_in     = wr_img.d0_in;
            nxt.wake      = wr_img.wake;
            nxt.clk_v     = merged.clk;
            nxt.d1_v      = merged.d1;
            nxt.d0_v      = merged.d0;
            nxt.cs_v      = merged.cs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/sst_pad_mux.sv
module sst_pad_mux
    import spi_systest_pkg::*;
(
    input  logic     test_mode,
    input  sst_reg_t r,
    input  pad_vec_t func_o,
    input  pad_vec_t func_oe,
    output pad_vec_t pad_o,
    output pad_vec_t pad_oe
);
    pad_vec_t tst_o;
    pad_vec_t tst_oe;

    always_comb begin
        tst_o  = values_of(r);
        tst_oe = ~input_mask(r);
        pad_o  = test_mode ? tst_o  : func_o;
        pad_oe = test_mode ? tst_oe : func_oe;
    end
endmodule

// File: rtl/spi_systest_pad.sv
module spi_systest_pad
    import spi_systest_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h24,
    parameter int              IRQ_W       = 4,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              test_mode,
    input  logic [IRQ_W-1:0]  irq_clr_req,
    output logic [IRQ_W-1:0]  irq_clr_ok,
    output logic              irq_set_all,
    output logic              wake_o,
    input  logic              func_clk_o,
    input  logic              func_clk_oe,
    input  logic [3:0]        func_cs_o,
    input  logic [3:0]        func_cs_oe,
    input  logic [1:0]        func_d_o,
    input  logic [1:0]        func_d_oe,
    input  logic              pad_clk_i,
    input  logic [3:0]        pad_cs_i,
    input  logic [1:0]        pad_d_i,
    output logic              pad_clk_o,
    output logic              pad_clk_oe,
    output logic [3:0]        pad_cs_o,
    output logic [3:0]        pad_cs_oe,
    output logic [1:0]        pad_d_o,
    output logic [1:0]        pad_d_oe
);
    logic     hit;
    sst_reg_t r;
    pad_vec_t pads_raw, pads_sync;
    pad_vec_t f_o, f_oe, p_o, p_oe;

    assign hit = (addr == REG_OFFSET);

    sst_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_en && hit),
        .wbits  (wdata[USED_W-1:0]),
        .q      (r)
    );

    assign pads_raw = {pad_clk_i, pad_d_i[1], pad_d_i[0], pad_cs_i};

    sst_sync #(.WIDTH(PAD_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pads_raw),
        .q   (pads_sync)
    );

    assign f_o  = {func_clk_o,  func_d_o[1],  func_d_o[0],  func_cs_o};
    assign f_oe = {func_clk_oe, func_d_oe[1], func_d_oe[0], func_cs_oe};

    sst_pad_mux u_mux (
        .test_mode (test_mode),
        .r         (r),
        .func_o    (f_o),
        .func_oe   (f_oe),
        .pad_o     (p_o),
        .pad_oe    (p_oe)
    );

    assign pad_clk_o  = p_o.clk;
    assign pad_clk_oe = p_oe.clk;
    assign pad_d_o    = {p_o.d1,  p_o.d0};
    assign pad_d_oe   = {p_oe.d1, p_oe.d0};
    assign pad_cs_o   = p_o.cs;
    assign pad_cs_oe  = p_oe.cs;

    assign rdata       = (rd_en && hit) ? readback(r, pads_sync) : '0;
    assign irq_set_all = r.force_sts;
    assign irq_clr_ok  = irq_clr_req & {IRQ_W{~r.force_sts}};
    assign wake_o      = r.wake;
endmodule

// File: rtl/spi_systest_chk.sv
module spi_systest_chk #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h24,
    parameter int                IRQ_W      = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              test_mode,
    input logic [IRQ_W-1:0]  irq_clr_ok,
    input logic              irq_set_all,
    input logic              wake_o,
    input logic              func_clk_o,
    input logic              pad_clk_o,
    input logic [3:0]        pad_cs_oe
);
    logic hit;
    assign hit = (addr == REG_OFFSET);

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rdata[31:12] == '0);

    p_force_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> irq_set_all == $past(wdata[11]));

    p_clr_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        irq_set_all |-> irq_clr_ok == '0);

    p_cs_dir_in_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit && wdata[10]) |=> (!test_mode || pad_cs_oe == '0));

    p_wake_drive_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> wake_o == $past(wdata[7]));

    p_func_owns_r10: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> pad_clk_o == func_clk_o);

    p_other_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit) |=> ($stable(irq_set_all) && $stable(wake_o)));
endmodule

bind spi_systest_pad spi_systest_chk #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .IRQ_W(IRQ_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .test_mode(test_mode),
    .irq_clr_ok(irq_clr_ok), .irq_set_all(irq_set_all), .wake_o(wake_o),
    .func_clk_o(func_clk_o), .pad_clk_o(pad_clk_o), .pad_cs_oe(pad_cs_oe)
);

// File: tb/tb_spi_systest_pad.sv
module tb_spi_systest_pad;
    localparam int IRQ_W = 4;

    logic clk = 0;
    always #5ns clk = ~clk;

    logic rst, wr_en, rd_en, test_mode;
    logic [7:0] addr;
    logic [31:0] wdata, rdata;
    logic [IRQ_W-1:0] irq_clr_req, irq_clr_ok;
    logic irq_set_all, wake_o;
    logic func_clk_o, func_clk_oe;
    logic [3:0] func_cs_o, func_cs_oe;
    logic [1:0] func_d_o, func_d_oe;
    logic pad_clk_i;
    logic [3:0] pad_cs_i;
    logic [1:0] pad_d_i;
    logic pad_clk_o, pad_clk_oe;
    logic [3:0] pad_cs_o, pad_cs_oe;
    logic [1:0] pad_d_o, pad_d_oe;

    spi_systest_pad dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .test_mode(test_mode),
        .irq_clr_req(irq_clr_req), .irq_clr_ok(irq_clr_ok),
        .irq_set_all(irq_set_all), .wake_o(wake_o),
        .func_clk_o(func_clk_o), .func_clk_oe(func_clk_oe),
        .func_cs_o(func_cs_o), .func_cs_oe(func_cs_oe),
        .func_d_o(func_d_o), .func_d_oe(func_d_oe),
        .pad_clk_i(pad_clk_i), .pad_cs_i(pad_cs_i), .pad_d_i(pad_d_i),
        .pad_clk_o(pad_clk_o), .pad_clk_oe(pad_clk_oe),
        .pad_cs_o(pad_cs_o), .pad_cs_oe(pad_cs_oe),
        .pad_d_o(pad_d_o), .pad_d_oe(pad_d_oe)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [11:0] m;   // reference register image

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] in_mask(logic [11:0] r);
        return {r[10], r[9], r[8], {4{r[10]}}};
    endfunction

    function automatic void model_write(logic [11:0] w);
        logic [6:0] k;
        k = in_mask(m);
        m[11:7] = w[11:7];
        m[6:0]  = (k & m[6:0]) | (~k & w[6:0]);
    endfunction

    function automatic logic [31:0] exp_read(logic [6:0] pads);
        logic [6:0] k;
        k = in_mask(m);
        return {20'd0, m[11:7], (k & pads) | (~k & m[6:0])};
    endfunction

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; addr = 8'h00; wdata = '0;
    endtask

    task automatic bus_read(output logic [31:0] d);
        rd_en = 1; addr = 8'h24;
        #1ns;
        d = rdata;
        rd_en = 0; addr = 8'h00;
    endtask

    task automatic set_pads(logic [6:0] p);
        {pad_clk_i, pad_d_i[1], pad_d_i[0], pad_cs_i} = p;
    endtask

    function automatic logic [6:0] oe_vec();
        return {pad_clk_oe, pad_d_oe[1], pad_d_oe[0], pad_cs_oe};
    endfunction

    function automatic logic [6:0] o_vec();
        return {pad_clk_o, pad_d_o[1], pad_d_o[0], pad_cs_o};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; test_mode = 1;
        irq_clr_req = '0;
        func_clk_o = 0; func_clk_oe = 0; func_cs_o = 0; func_cs_oe = 0;
        func_d_o = 0; func_d_oe = 0;
        set_pads(7'h00);
        m = '0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        bus_read(rd);
        chk("R1 read", rd, 32'h0);
        chk("R1 oe", {25'd0, oe_vec()}, 32'h7F);
        chk("R1 o", {25'd0, o_vec()}, 32'h0);
        chk("R1 set_all/wake", {30'd0, irq_set_all, wake_o}, 32'h0);

        // R2 reserved bits
        bus_write(8'h24, 32'hFFFF_F000);
        model_write(12'h000);
        bus_read(rd);
        chk("R2 reserved read", rd, 32'h0);

        // R8 writes to value bits ignored while input
        bus_write(8'h24, 32'h700); model_write(12'h700);
        bus_write(8'h24, 32'h77F); model_write(12'h77F);
        bus_write(8'h24, 32'h000); model_write(12'h000);
        chk("R8 kept value", {25'd0, o_vec()}, 32'h0);
        bus_write(8'h24, 32'h07F); model_write(12'h07F);
        chk("R8 output written", {25'd0, o_vec()}, 32'h7F);

        // R3/R4 force bit colliding with clear requests
        irq_clr_req = 4'hA;
        @(negedge clk);
        chk("R4 pass before", {28'd0, irq_clr_ok}, 32'hA);
        wr_en = 1; addr = 8'h24; wdata = 32'h800;
        #1ns;
        chk("R4 same-cycle before edge", {28'd0, irq_clr_ok}, 32'hA);
        @(negedge clk);
        wr_en = 0; addr = 0; wdata = 0;
        model_write(12'h800);
        chk("R3 set_all high", {31'd0, irq_set_all}, 32'h1);
        chk("R4 blocked", {28'd0, irq_clr_ok}, 32'h0);
        bus_read(rd);
        chk("R3 readback", rd, exp_read(7'h00));
        bus_write(8'h24, 32'h000); model_write(12'h000);
        chk("R3 released", {31'd0, irq_set_all}, 32'h0);
        chk("R4 pass after", {28'd0, irq_clr_ok}, 32'hA);
        irq_clr_req = '0;

        // R11 wrong offset ignored
        bus_write(8'h20, 32'hFFF);
        bus_read(rd);
        chk("R11 other offset", rd, exp_read(7'h00));
        chk("R11 other offset set_all", {31'd0, irq_set_all}, 32'h0);

        // R5/R6/R7/R8/R11 sweep over directions and values
        for (int d = 0; d < 8; d++) begin
            for (int v = 0; v < 128; v++) begin
                logic [6:0] p;
                logic [11:0] w;
                p = 7'(v) ^ 7'h5A ^ 7'(d * 19);
                w = {1'b0, 3'(d), v[0], 7'(v)};
                @(negedge clk);
                set_pads(p);
                wr_en = 1; addr = 8'h24; wdata = {20'd0, w};
                @(negedge clk);
                wr_en = 0; addr = 0; wdata = 0;
                model_write(w);
                chk("R5 oe", {25'd0, oe_vec()}, {25'd0, ~in_mask(m)});
                chk("R6 drive", {25'd0, o_vec()}, {25'd0, m[6:0]});
                @(negedge clk);
                bus_read(rd);
                chk("R7 readback", rd, exp_read(p));
            end
        end

        // R9 wake outside test mode
        test_mode = 0;
        bus_write(8'h24, 32'h080); model_write(12'h080);
        chk("R9 wake high", {31'd0, wake_o}, 32'h1);
        bus_write(8'h24, 32'h000); model_write(12'h000);
        chk("R9 wake low", {31'd0, wake_o}, 32'h0);

        // R10 functional ownership
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            {func_clk_o, func_d_o[1], func_d_o[0], func_cs_o} = 7'(i);
            {func_clk_oe, func_d_oe[1], func_d_oe[0], func_cs_oe} = ~7'(i * 5);
            #1ns;
            chk("R10 o", {25'd0, o_vec()}, {25'd0, 7'(i)});
            chk("R10 oe", {25'd0, oe_vec()}, {25'd0, ~7'(i * 5)});
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule